// File: doc/BRIEF.md
# Programmable External Bus Cycle Sequencer

This block runs one external memory access for a single chip-select region. An internal requester pulses `start` together with an address, a read/write flag and write data. The sequencer then steps through six phases whose lengths come from a packed timing word, and drives chip select, address latch enable, the read and write strobes, the address bus and the shared address/data lanes with their per-lane output enables. At the end it returns captured read data and raises `done` for one cycle.

A mode input picks an 8- or 16-bit data path and a multiplexed or separate address bus. Three further inputs decide whether an external ready line may stretch the command phase, whether that line is already synchronous to the clock, and which level of it means "ready". All configuration is latched when a cycle starts.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset `cs_n`, `rd_n` and `wr_n` are 1, `ale` and `done` are 0, `busy` is 0 and `ad_oe` is 0.
- R2: The timing word packs, from bit 0 upward, setup [1:0] (0-3 cycles), latch [2] (value+1 cycles), gap [4:3] (0-3), turn [5] (0-1), command [10:6] (value+1 cycles, 1-32), read hold [12:11] (0-3) and write hold [14:13] (0-3). With `start` sampled at edge 0, `done` is high in the cycle after edge N, where N is the sum of all phase lengths used.
- R3: `cs_n` is low for exactly latch+gap+turn+command+hold cycles and high during setup and the done cycle.
- R4: Exactly one strobe is low, only during the command phase: `rd_n` for reads (`wr`=0), `wr_n` for writes.
- R5: The hold phase uses the read-hold field for reads and the write-hold field for writes.
- R6: `mode` bit 0 = 1 selects multiplexed operation: `ale` is high for the latch phase and the lanes carry address bits [15:0] during latch and gap. With bit 0 = 0, `ale` stays low and a read never enables the lanes.
- R7: `mode` bit 1 = 0 selects an 8-bit path: the upper lane enable `ad_oe[1]` never rises and `rdata` is the low lane zero-extended. Bit 1 = 1 uses both lanes.
- R8: Read data on `ad_in` is captured in the last command cycle and held on `rdata`; write data drives the lanes for command and hold phases of a write.
- R9: With `rdy_use`=1 the command phase lasts at least its programmed length and then ends at the first edge where ready is active. With `rdy_sync`=1 the line is used directly.
- R10: With `rdy_sync`=0 the ready line passes two flip-flops first, so the command phase ends two cycles later than in synchronous use.
- R11: `rdy_high`=1 makes a high ready line active; `rdy_high`=0 makes a low line active.
- R12: `start` while `busy` is ignored, and `done` lasts exactly one cycle per accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse for one access |
| addr | input | ADDR_W | Access address |
| wr | input | 1 | 1 = write, 0 = read |
| wdata | input | 16 | Write data |
| timing | input | 15 | Packed phase lengths |
| mode | input | 2 | bit1 = 16-bit, bit0 = multiplexed |
| rdy_use | input | 1 | Let ready stretch the command phase |
| rdy_sync | input | 1 | Ready line already synchronous |
| rdy_high | input | 1 | Ready active level is high |
| rdy_in | input | 1 | External ready line |
| ad_in | input | 16 | Lane input data |
| cs_n | output | 1 | Chip select, active low |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_out | output | ADDR_W | Address bus |
| ad_out | output | 16 | Lane output data |
| ad_oe | output | 2 | Per-lane output enable |
| rdata | output | 16 | Captured read data |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Access in progress |

## Verification
A wrong phase state or counter shows directly as a changed count of cycles with `cs_n` low or a strobe low, and as a shifted `done`, all visible within the same access. A wrong latched mode shows as `ale` pulses in separate-bus mode or an upper lane driven on an 8-bit path during that access. A broken ready path shows as a command phase one or two cycles off its expected length, and a busy flag that does not block a second start shows as extra chip-select activity right after `done`.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [15:0]       wdata,
  input  logic [14:0]       timing,
  input  logic [1:0]        mode,
  input  logic              rdy_use,
  input  logic              rdy_sync,
  input  logic              rdy_high,
  input  logic              rdy_in,
  input  logic [15:0]       ad_in,
  output logic              cs_n,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic [ADDR_W-1:0] addr_out,
  output logic [15:0]       ad_out,
  output logic [1:0]        ad_oe,
  output logic [15:0]       rdata,
  output logic              done,
  output logic              busy
);
  typedef enum logic [2:0] {S_IDLE, S_A, S_B, S_C, S_D, S_E, S_F, S_DONE} ph_t;

  ph_t              ph, ph_nx;
  logic [4:0]       cnt, lim;
  logic [14:0]      tq;
  logic [1:0]       mode_q;
  logic             wr_q, use_q, sync_q, high_q;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]      wdata_q;
  logic             s1, s2;

  wire [1:0] t_a  = tq[1:0];
  wire       t_b  = tq[2];
  wire [1:0] t_c  = tq[4:3];
  wire       t_d  = tq[5];
  wire [4:0] t_e  = tq[10:6];
  wire [1:0] t_f  = wr_q ? tq[14:13] : tq[12:11];
  wire [1:0] st_a = timing[1:0];

  wire rdy_line = sync_q ? rdy_in : s2;
  wire rdy_ok   = !use_q || (rdy_line == high_q);

  always_comb begin
    case (ph)
      S_A:     lim = {3'd0, t_a - 2'd1};
      S_B:     lim = {4'd0, t_b};
      S_C:     lim = {3'd0, t_c - 2'd1};
      S_E:     lim = t_e;
      S_F:     lim = {3'd0, t_f - 2'd1};
      default: lim = 5'd0;
    endcase
  end

  wire ph_end = (cnt >= lim) && (ph != S_E || rdy_ok);

  always_comb begin
    ph_nx = ph;
    case (ph)
      S_IDLE: if (start) ph_nx = (st_a != 2'd0) ? S_A : S_B;
      S_A:    if (ph_end) ph_nx = S_B;
      S_B:    if (ph_end) ph_nx = (t_c != 2'd0) ? S_C : (t_d ? S_D : S_E);
      S_C:    if (ph_end) ph_nx = t_d ? S_D : S_E;
      S_D:    if (ph_end) ph_nx = S_E;
      S_E:    if (ph_end) ph_nx = (t_f != 2'd0) ? S_F : S_DONE;
      S_F:    if (ph_end) ph_nx = S_DONE;
      default: ph_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= S_IDLE;
      cnt <= '0;
      tq <= '0;
      mode_q <= '0;
      wr_q <= 1'b0;
      use_q <= 1'b0;
      sync_q <= 1'b0;
      high_q <= 1'b0;
      addr_q <= '0;
      wdata_q <= '0;
      rdata <= '0;
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= rdy_in;
      s2 <= s1;
      ph <= ph_nx;
      if (ph_nx != ph) cnt <= '0;
      else if (cnt != 5'd31) cnt <= cnt + 5'd1;
      if (ph == S_IDLE && start) begin
        tq <= timing;
        mode_q <= mode;
        wr_q <= wr;
        use_q <= rdy_use;
        sync_q <= rdy_sync;
        high_q <= rdy_high;
        addr_q <= addr;
        wdata_q <= wdata;
      end
      if (ph == S_E && ph_end && !wr_q)
        rdata <= mode_q[1] ? ad_in : {8'h00, ad_in[7:0]};
    end
  end

  wire in_ab  = (ph == S_B) || (ph == S_C);
  wire in_cmd = (ph == S_E);
  wire drive  = (mode_q[0] && in_ab) || (wr_q && (in_cmd || ph == S_F));

  assign cs_n     = !(ph inside {S_B, S_C, S_D, S_E, S_F});
  assign ale      = mode_q[0] && (ph == S_B);
  assign rd_n     = !(in_cmd && !wr_q);
  assign wr_n     = !(in_cmd && wr_q);
  assign addr_out = addr_q;
  assign ad_out   = in_ab ? addr_q[15:0] : wdata_q;
  assign ad_oe    = {drive && mode_q[1], drive};
  assign done     = (ph == S_DONE);
  assign busy     = (ph != S_IDLE);
endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic cs_n,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic done
);
  assert_idle_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && rd_n && wr_n && !ale));
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_strobe_in_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !cs_n);
  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  assert_ale_in_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (!cs_n && rd_n && wr_n));
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_cs_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);
endmodule

bind ext_bus_seq ext_bus_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .cs_n(cs_n),
  .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .done(done)
);

// File: tb/sim_ext_bus_seq.sv
module sim_ext_bus_seq;
  logic clk = 0, rst_n = 0, start = 0, wr = 0;
  logic [23:0] addr = 0;
  logic [15:0] wdata = 0, ad_in = 16'hA55A;
  logic [14:0] timing = 0;
  logic [1:0]  mode = 0;
  logic rdy_use = 0, rdy_sync = 0, rdy_high = 0, rdy_in = 0;
  logic cs_n, ale, rd_n, wr_n, done, busy;
  logic [23:0] addr_out;
  logic [15:0] ad_out, rdata;
  logic [1:0]  ad_oe;
  int errs = 0, checks = 0;
  int lat, n_cs, n_ale, n_rd, n_wr, n_oe0, n_oe1, tail_cs, tail_done;
  logic [15:0] ale_val, wr_val;

  always #10 clk = ~clk;

  ext_bus_seq #(.ADDR_W(24)) u0 (.*);

  function automatic logic [14:0] mk(int a, int b, int c, int d, int e, int fr, int fw);
    return {fw[1:0], fr[1:0], e[4:0], d[0], c[1:0], b[0], a[1:0]};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(logic [14:0] tm, logic [1:0] md, logic w, logic [23:0] a, logic [15:0] wd,
                     logic ru, logic rs, logic rh, int rdy_after, int restart_at);
    @(negedge clk);
    timing = tm; mode = md; wr = w; addr = a; wdata = wd;
    rdy_use = ru; rdy_sync = rs; rdy_high = rh;
    rdy_in = (rdy_after == 0) ? rh : !rh;
    start = 1;
    @(negedge clk);
    start = 0;
    lat = 0; n_cs = 0; n_ale = 0; n_rd = 0; n_wr = 0; n_oe0 = 0; n_oe1 = 0;
    tail_cs = 0; tail_done = 0; ale_val = 'x; wr_val = 'x;
    for (int i = 0; i < 300; i++) begin
      lat++;
      if (!cs_n) n_cs++;
      if (ale) begin n_ale++; ale_val = ad_out; end
      if (!rd_n) n_rd++;
      if (!wr_n) begin n_wr++; wr_val = ad_out; end
      if (ad_oe[0]) n_oe0++;
      if (ad_oe[1]) n_oe1++;
      if (rdy_after != 0 && (n_rd + n_wr) == rdy_after) rdy_in = rh;
      if (restart_at != 0 && lat == restart_at) begin
        start = 1; timing = mk(3, 1, 3, 1, 20, 3, 3); mode = 2'd3;
      end else start = 0;
      if (done) break;
      @(negedge clk);
    end
    start = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!cs_n) tail_cs++;
      if (done) tail_done++;
    end
  endtask

  task automatic t_reset;
    chk("R1 cs_n", cs_n, 1); chk("R1 rd_n", rd_n, 1); chk("R1 wr_n", wr_n, 1);
    chk("R1 ale", ale, 0); chk("R1 done", done, 0); chk("R1 busy", busy, 0);
    chk("R1 ad_oe", ad_oe, 0);
  endtask

  task automatic t_read_demux16;
    run(mk(1, 0, 2, 1, 3, 2, 1), 2'd2, 0, 24'h12_3456, 16'h0, 0, 1, 1, 0, 0);
    chk("R2 latency", lat, 12);
    chk("R3 cs cycles", n_cs, 10);
    chk("R4 rd cycles", n_rd, 4);
    chk("R4 wr cycles", n_wr, 0);
    chk("R6 no ale demux", n_ale, 0);
    chk("R6 no lane drive on demux read", n_oe0, 0);
    chk("R8 rdata 16", rdata, 16'hA55A);
    chk("R2 addr_out", addr_out, 24'h12_3456);
  endtask

  task automatic t_write_mux16;
    run(mk(0, 1, 0, 0, 0, 3, 1), 2'd3, 1, 24'h00_BEEF, 16'h5AA5, 0, 1, 1, 0, 0);
    chk("R2 latency", lat, 5);
    chk("R3 cs cycles", n_cs, 4);
    chk("R4 wr cycles", n_wr, 1);
    chk("R4 rd cycles", n_rd, 0);
    chk("R5 write hold field used", n_cs - 2 - 1, 1);
    chk("R6 ale cycles", n_ale, 2);
    chk("R6 address on lanes", ale_val, 16'hBEEF);
    chk("R8 write data on lanes", wr_val, 16'h5AA5);
    chk("R7 upper lane driven 16-bit", n_oe1, 4);
  endtask

  task automatic t_read_mux8;
    run(mk(3, 1, 1, 0, 5, 0, 3), 2'd1, 0, 24'h00_1234, 16'h0, 0, 1, 1, 0, 0);
    chk("R2 latency", lat, 13);
    chk("R5 read hold field used", n_cs, 9);
    chk("R6 ale cycles", n_ale, 2);
    chk("R6 low byte address", ale_val[7:0], 8'h34);
    chk("R7 upper lane idle", n_oe1, 0);
    chk("R7 rdata 8-bit", rdata, 16'h005A);
  endtask

  task automatic t_write_demux8_long;
    run(mk(0, 0, 0, 0, 31, 0, 3), 2'd0, 1, 24'h0, 16'hC3C3, 0, 1, 1, 0, 0);
    chk("R2 latency max command", lat, 37);
    chk("R4 wr cycles 32", n_wr, 32);
    chk("R8 lanes driven cmd+hold", n_oe0, 35);
    chk("R7 upper lane idle", n_oe1, 0);
    chk("R6 no ale demux", n_ale, 0);
  endtask

  task automatic t_ready;
    run(mk(0, 0, 0, 0, 1, 0, 0), 2'd2, 0, 24'h0, 16'h0, 1, 1, 1, 0, 0);
    chk("R9 ready already active", n_rd, 2);
    run(mk(0, 0, 0, 0, 1, 0, 0), 2'd2, 0, 24'h0, 16'h0, 1, 1, 1, 6, 0);
    chk("R9 sync ready stretch", n_rd, 6);
    chk("R9 latency", lat, 8);
    run(mk(0, 0, 0, 0, 1, 0, 0), 2'd2, 0, 24'h0, 16'h0, 1, 0, 1, 6, 0);
    chk("R10 async ready stretch", n_rd, 8);
    run(mk(0, 0, 0, 0, 1, 0, 0), 2'd2, 0, 24'h0, 16'h0, 1, 1, 0, 6, 0);
    chk("R11 active-low ready", n_rd, 6);
    run(mk(0, 0, 0, 0, 1, 0, 0), 2'd2, 0, 24'h0, 16'h0, 0, 1, 1, 6, 0);
    chk("R9 ready ignored when unused", n_rd, 2);
  endtask

  task automatic t_busy;
    run(mk(0, 1, 1, 0, 2, 1, 0), 2'd2, 0, 24'h0, 16'h0, 0, 1, 1, 0, 3);
    chk("R12 latency unaffected", lat, 8);
    chk("R12 no second access", tail_cs, 0);
    chk("R12 single done", tail_done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_read_demux16;
    t_write_mux16;
    t_read_mux8;
    t_write_demux8_long;
    t_ready;
    t_busy;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule